// File: doc/BRIEF.md
# Synchronous Burst SRAM with Byte-Lane Writes

This block is a single-clock static RAM with a 36-bit word made of four 9-bit byte lanes. Address, write data and every control input are sampled on the rising clock edge. Reads are flow-through: once an address is registered, its word is presented in that same cycle, with no output register in the path.

A burst is opened by either of two address strobes. One strobe, meant for a processor, always opens a read. The other, meant for a cache controller, honours the write controls. A 2-bit counter then replaces the two low address bits. Each cycle with the advance input asserted moves it one step. A mode input chooses a linear or an interleaved walk through the four words of the aligned block. Three chip enables must agree before the part responds. Writes can cover any set of lanes, or all four through a global write that overrides the per-lane controls. The data output goes to a pad through a separate output-enable signal.

Top module: `burst_sram`

## Requirements
- R1: Inputs are registered on the rising edge, and reads are flow-through. The word at an address loaded at an edge is on `rdData` in the cycle that follows that edge. A write presented at an edge is visible to reads from the next cycle on.
- R2: The part is selected only when `chipEn0N`=0, `chipEn1`=1 and `chipEn2N`=0. If any of them is false at an edge, the next cycle is a deselect: `parked`=1, `rdOe`=0, and no lane is written.
- R3: When the part is selected and either `procStrobeN` or `ctrlStrobeN` is low, `addrIn` is loaded as the burst start and the burst count is set to 0. A new strobe in the middle of a burst restarts it.
- R4: A cycle started with `procStrobeN` low is always a read. Global and per-lane write controls have no effect in that cycle. `procStrobeN` takes priority over `ctrlStrobeN`.
- R5: In a selected cycle with both strobes high, `advanceN`=0 steps the burst count by one, modulo 4, so the walk wraps after four words. `advanceN`=1 holds the current word.
- R6: With `interleave`=0, the two low address bits are (start low bits + count) mod 4. The upper bits stay those of the loaded address.
- R7: With `interleave`=1, the two low address bits are start low bits XOR count.
- R8: With `globalWrN`=1, lane i (bits 9i+8..9i) is written when `byteWrEnN`=0 and `laneWrN[i]`=0. With `byteWrEnN`=1, no lane is written.
- R9: With `globalWrN`=0 in a selected cycle that is not a processor-strobe start, all four lanes are written, whatever `byteWrEnN` and `laneWrN` hold.
- R10: `rdOe` is 1 only in a selected cycle that writes no lane while `outEnN`=0. When `rdOe` is 0, `rdData` is all zeros.
- R11: While the part is deselected, the burst count and start address hold, and an asserted `advanceN` is ignored.
- R12: While `rstN` is low and in the cycle right after it, `parked`=1, `rdOe`=0 and `rdData`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Synchronous reset of the control state, active low |
| addrIn | input | ADDR_W | Word address loaded by a strobe |
| procStrobeN | input | 1 | Processor burst start, read only, active low |
| ctrlStrobeN | input | 1 | Controller burst start, active low |
| advanceN | input | 1 | Step the burst count, active low |
| chipEn0N | input | 1 | Chip enable, active low |
| chipEn1 | input | 1 | Chip enable, active high |
| chipEn2N | input | 1 | Chip enable, active low |
| globalWrN | input | 1 | Write all lanes, active low |
| byteWrEnN | input | 1 | Qualifies the per-lane write bits, active low |
| laneWrN | input | 4 | Per-lane write select, active low |
| outEnN | input | 1 | Output enable, active low |
| interleave | input | 1 | Burst order: 0 linear, 1 interleaved |
| wrData | input | 36 | Write data, lane i in bits 9i+8..9i |
| rdData | output | 36 | Read word, zero when not driven |
| rdOe | output | 1 | Pad drive enable for rdData |
| parked | output | 1 | High during a deselect cycle |

## Verification
The bench builds the block with `ADDR_W`=4, a 16-word array. At that size it can fill every word with a distinct pattern and keep its own model of the whole array. Any stray write then shows up when a word is read back later, whichever address the write hit. With four aligned 4-word blocks, the bench can start bursts at every offset in both orders and watch them wrap inside their own block, not spill into a neighbouring one.

// File: rtl/sbram_pkg.sv
package sbram_pkg;
  localparam int LANES  = 4;
  localparam int LANE_W = 9;
  localparam int WORD_W = LANES * LANE_W;

  // Registered command handed from control to datapath
  typedef struct packed {
    logic             cycleOn;  // selected cycle
    logic [LANES-1:0] laneWe;   // lanes to commit at the next edge
  } ctlStrobe_t;
endpackage

// File: rtl/sbram_ctrl.sv
module sbram_ctrl
  import sbram_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              procStrobeN,
  input  logic              ctrlStrobeN,
  input  logic              advanceN,
  input  logic              chipEn0N,
  input  logic              chipEn1,
  input  logic              chipEn2N,
  input  logic              globalWrN,
  input  logic              byteWrEnN,
  input  logic [LANES-1:0]  laneWrN,
  input  logic              interleave,
  output logic [ADDR_W-1:0] wordAddr,
  output ctlStrobe_t        strobe,
  output logic              parked
);
  localparam int CNT_W = 2;

  logic              selNow, startNow, stepNow;
  logic [LANES-1:0]  weNext;
  logic [ADDR_W-1:0] baseQ;
  logic [CNT_W-1:0]  cntQ, offset;
  ctlStrobe_t        strobeQ;

  assign selNow   = !chipEn0N && chipEn1 && !chipEn2N;
  assign startNow = selNow && (!procStrobeN || !ctrlStrobeN);
  assign stepNow  = selNow && procStrobeN && ctrlStrobeN && !advanceN;

  // Write decode: processor start is read only, global write beats lanes
  always_comb begin
    if (!selNow || !procStrobeN) weNext = '0;
    else if (!globalWrN)         weNext = '1;
    else if (!byteWrEnN)         weNext = ~laneWrN;
    else                         weNext = '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      strobeQ <= '0;
      baseQ   <= '0;
      cntQ    <= '0;
    end else begin
      strobeQ.cycleOn <= selNow;
      strobeQ.laneWe  <= weNext;
      if (startNow) begin
        baseQ <= addrIn;
        cntQ  <= '0;
      end else if (stepNow) begin
        cntQ <= cntQ + CNT_W'(1);
      end
    end
  end

  always_comb begin
    if (interleave) offset = baseQ[CNT_W-1:0] ^ cntQ;
    else            offset = baseQ[CNT_W-1:0] + cntQ;
  end

  assign wordAddr = {baseQ[ADDR_W-1:CNT_W], offset};
  assign strobe   = strobeQ;
  assign parked   = !strobeQ.cycleOn;

  AST_START_LOADS: assert property (@(posedge clk) disable iff (!rstN)
    startNow |=> (cntQ == '0) && (wordAddr[ADDR_W-1:CNT_W] == $past(addrIn[ADDR_W-1:CNT_W]))); // R3
  AST_PROC_IS_READ: assert property (@(posedge clk) disable iff (!rstN)
    (selNow && !procStrobeN) |=> (strobe.laneWe == '0)); // R4
  AST_ADVANCE_STEPS: assert property (@(posedge clk) disable iff (!rstN)
    stepNow |=> (cntQ == $past(cntQ) + CNT_W'(1))); // R5
  AST_GLOBAL_ALL_LANES: assert property (@(posedge clk) disable iff (!rstN)
    (selNow && procStrobeN && !globalWrN) |=> (&strobe.laneWe)); // R9
  AST_DESELECT_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !selNow |=> ($stable(cntQ) && $stable(baseQ) && parked)); // R11
endmodule

// File: rtl/sbram_data.sv
module sbram_data
  import sbram_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strobe,
  input  logic [ADDR_W-1:0] wordAddr,
  input  logic [WORD_W-1:0] wrData,
  input  logic              outEnN,
  output logic [WORD_W-1:0] rdData,
  output logic              rdOe
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [WORD_W-1:0] dataQ, wordNow;

  always_ff @(posedge clk) begin
    if (!rstN) dataQ <= '0;
    else       dataQ <= wrData;
  end

  // One bank per byte lane; commit happens at the edge after the command
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] bank [DEPTH];
    always_ff @(posedge clk) begin
      if (strobe.cycleOn && strobe.laneWe[g])
        bank[wordAddr] <= dataQ[g*LANE_W +: LANE_W];
    end
    assign wordNow[g*LANE_W +: LANE_W] = bank[wordAddr];
  end

  assign rdOe   = strobe.cycleOn && (strobe.laneWe == '0) && !outEnN;
  assign rdData = rdOe ? wordNow : '0;

  AST_WRITE_NEEDS_SELECT: assert property (@(posedge clk) disable iff (!rstN)
    (|strobe.laneWe) |-> strobe.cycleOn); // R2
endmodule

// File: rtl/burst_sram.sv
module burst_sram
  import sbram_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              procStrobeN,
  input  logic              ctrlStrobeN,
  input  logic              advanceN,
  input  logic              chipEn0N,
  input  logic              chipEn1,
  input  logic              chipEn2N,
  input  logic              globalWrN,
  input  logic              byteWrEnN,
  input  logic [3:0]        laneWrN,
  input  logic              outEnN,
  input  logic              interleave,
  input  logic [35:0]       wrData,
  output logic [35:0]       rdData,
  output logic              rdOe,
  output logic              parked
);
  ctlStrobe_t        strobe;
  logic [ADDR_W-1:0] wordAddr;

  sbram_ctrl #(.ADDR_W(ADDR_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .addrIn(addrIn),
    .procStrobeN(procStrobeN), .ctrlStrobeN(ctrlStrobeN), .advanceN(advanceN),
    .chipEn0N(chipEn0N), .chipEn1(chipEn1), .chipEn2N(chipEn2N),
    .globalWrN(globalWrN), .byteWrEnN(byteWrEnN), .laneWrN(laneWrN),
    .interleave(interleave), .wordAddr(wordAddr), .strobe(strobe), .parked(parked)
  );

  sbram_data #(.ADDR_W(ADDR_W)) i_data (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wordAddr(wordAddr),
    .wrData(wrData), .outEnN(outEnN), .rdData(rdData), .rdOe(rdOe)
  );
endmodule

// File: tb/test_burst_sram.sv
module test_burst_sram;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 4;
  localparam int WORDS = 1 << AW;

  logic clk = 0, rstN = 0;
  logic [AW-1:0] addrIn = '0;
  logic procStrobeN = 1, ctrlStrobeN = 1, advanceN = 1;
  logic chipEn0N = 0, chipEn1 = 1, chipEn2N = 0;
  logic globalWrN = 1, byteWrEnN = 1, outEnN = 0, interleave = 0;
  logic [3:0] laneWrN = 4'hf;
  logic [35:0] wrData = '0;
  logic [35:0] rdData;
  logic rdOe, parked;

  int checks = 0, errors = 0;
  logic [35:0] model [WORDS];

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_sram #(.ADDR_W(AW)) i_burst_sram (
    .clk(clk), .rstN(rstN), .addrIn(addrIn), .procStrobeN(procStrobeN),
    .ctrlStrobeN(ctrlStrobeN), .advanceN(advanceN), .chipEn0N(chipEn0N),
    .chipEn1(chipEn1), .chipEn2N(chipEn2N), .globalWrN(globalWrN),
    .byteWrEnN(byteWrEnN), .laneWrN(laneWrN), .outEnN(outEnN),
    .interleave(interleave), .wrData(wrData), .rdData(rdData), .rdOe(rdOe),
    .parked(parked)
  );

  function automatic logic [35:0] pat(input int a, input int salt);
    return {9'(a*7 + salt), 9'(a + 1), 9'(salt ^ a), 9'(a + 3*salt + 5)};
  endfunction

  task automatic check(input string req, input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // One bus cycle: inputs set at the falling edge, sampled at the next one
  task automatic drive(input logic pN, input logic cN, input logic aN, input int a,
                       input logic gwN, input logic bweN, input logic [3:0] lN,
                       input logic [35:0] d);
    procStrobeN = pN; ctrlStrobeN = cN; advanceN = aN; addrIn = AW'(a);
    globalWrN = gwN; byteWrEnN = bweN; laneWrN = lN; wrData = d;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic loadRead(input int a);
    drive(1, 0, 1, a, 1, 1, 4'hf, '0);
  endtask
  task automatic advRead();
    drive(1, 1, 0, 0, 1, 1, 4'hf, '0);
  endtask
  task automatic gwWrite(input int a, input logic [35:0] d);
    drive(1, 0, 1, a, 0, 1, 4'hf, d);
    model[a] = d;
  endtask

  task automatic testReset();
    repeat (3) @(negedge clk);
    check("R12 parked", 36'(parked), 36'(1));
    check("R12 rdOe", 36'(rdOe), 36'(0));
    check("R12 rdData", rdData, '0);
    rstN = 1;
  endtask

  task automatic testGlobalFill();
    for (int a = 0; a < WORDS; a++) gwWrite(a, pat(a, 1));
    loadRead(5);
    check("R9 R1 word5", rdData, model[5]);
    check("R10 rdOe on read", 36'(rdOe), 36'(1));
    loadRead(12);
    check("R9 word12", rdData, model[12]);
  endtask

  task automatic testByteLanes();
    logic [35:0] nd = 36'h5a5a5a5a5;
    // lanes 0 and 2 selected (laneWrN=1010)
    drive(1, 0, 1, 3, 1, 0, 4'b1010, nd);
    check("R10 no drive on write", 36'(rdOe), 36'(0));
    model[3][8:0]   = nd[8:0];
    model[3][26:18] = nd[26:18];
    loadRead(3);
    check("R8 lanes 0,2 merged", rdData, model[3]);
    // lane bits low but byte enable high: nothing written
    drive(1, 0, 1, 3, 1, 1, 4'b0000, 36'h0);
    loadRead(3);
    check("R8 byte enable off", rdData, model[3]);
    // global write overrides lanes held off
    gwWrite(4, 36'h123456789);
    loadRead(4);
    check("R9 global overrides", rdData, model[4]);
  endtask

  task automatic testProcRead();
    drive(0, 0, 1, 7, 0, 0, 4'h0, 36'hfffffffff);
    check("R4 proc start reads", rdData, model[7]);
    check("R4 proc rdOe", 36'(rdOe), 36'(1));
    loadRead(7);
    check("R4 write ignored", rdData, model[7]);
  endtask

  task automatic runBurst(input string req, input logic mode, input int start);
    interleave = mode;
    loadRead(start);
    check(req, rdData, model[start]);
    for (int k = 1; k < 5; k++) begin
      int off = mode ? ((start & 3) ^ (k & 3)) : (((start & 3) + k) & 3);
      advRead();
      check(req, rdData, model[(start & ~3) | off]);
    end
  endtask

  task automatic testBursts();
    runBurst("R6 linear from 9", 0, 9);
    runBurst("R6 linear from 3", 0, 3);
    runBurst("R7 interleave from 6", 1, 6);
    runBurst("R7 interleave from 13", 1, 13);
    interleave = 0;
  endtask

  task automatic testHoldAndRestart();
    loadRead(9);
    drive(1, 1, 1, 0, 1, 1, 4'hf, '0);
    check("R5 no advance holds", rdData, model[9]);
    advRead();
    check("R5 advance steps", rdData, model[10]);
    loadRead(0);
    check("R3 restart mid-burst", rdData, model[0]);
    advRead();
    check("R3 count cleared", rdData, model[1]);
  endtask

  task automatic testDeselect();
    loadRead(9);
    chipEn1 = 0;
    advRead();
    check("R2 chipEn1 parked", 36'(parked), 36'(1));
    check("R2 chipEn1 rdOe", 36'(rdOe), 36'(0));
    advRead();
    chipEn1 = 1;
    advRead();
    check("R11 counter held", rdData, model[10]);
    chipEn0N = 1;
    loadRead(1);
    check("R2 chipEn0N parked", 36'(parked), 36'(1));
    chipEn0N = 0; chipEn2N = 1;
    drive(1, 0, 1, 2, 0, 1, 4'hf, 36'h0f0f0f0f0);
    check("R2 chipEn2N parked", 36'(parked), 36'(1));
    chipEn2N = 0;
    advRead();
    check("R11 start kept after strobe while deselected", rdData, model[11]);
    loadRead(2);
    check("R2 no write when deselected", rdData, model[2]);
  endtask

  task automatic testBurstWrite();
    interleave = 0;
    drive(1, 0, 1, 14, 0, 1, 4'hf, 36'h111111111); model[14] = 36'h111111111;
    drive(1, 1, 0, 0, 0, 1, 4'hf, 36'h222222222); model[15] = 36'h222222222;
    drive(1, 1, 0, 0, 0, 1, 4'hf, 36'h333333333); model[12] = 36'h333333333;
    loadRead(14); check("R5 burst write 14", rdData, model[14]);
    loadRead(15); check("R5 burst write 15", rdData, model[15]);
    loadRead(12); check("R6 burst write wraps", rdData, model[12]);
    loadRead(13); check("R6 word 13 untouched", rdData, model[13]);
  endtask

  task automatic testOutEnable();
    outEnN = 1;
    loadRead(5);
    check("R10 outEn off rdOe", 36'(rdOe), 36'(0));
    check("R10 outEn off data", rdData, '0);
    outEnN = 0;
    loadRead(5);
    check("R1 R10 outEn on", rdData, model[5]);
  endtask

  initial begin
    testReset();
    testGlobalFill();
    testByteLanes();
    testProcRead();
    testBursts();
    testHoldAndRestart();
    testDeselect();
    testBurstWrite();
    testOutEnable();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule